// File: doc/BRIEF.md
# Shared-Memory Multi-Queue Word FIFO Manager

This block keeps 64 independent word queues inside one shared on-chip memory. Each queue is a circular buffer whose location, length and two warning thresholds come from a 32-bit configuration word. Software and engines reach the block through a simple one-cycle register bus. Writing a queue's access address appends a word to that queue. Reading the access address removes the oldest word. Packed status words report how full each queue is.

The register bus uses an 8-bit word address. Bits 7:6 pick the region: 0 is the access ports, 1 is the configuration words and 2 is the status words. Bits 5:0 give the queue number, or the status word index in the status region. Each queue keeps a read offset and an occupancy count. Its write slot is derived from those two, wrapping inside the queue's own length. A configuration write clears the queue. Read data appear on `bus_rdata_o` on the clock edge that follows the read strobe, and they stay there until the next read. When write and read are both asserted in one cycle, the write is taken and the read is dropped.

Top module: `qm_fifo_mgr`

## Requirements
- R1: A configuration word holds the base page (16 words per page) in bits 21:14 and the size code in bits 25:24. The codes 0, 1, 2 and 3 give 16, 32, 64 and 128 words. Writing queue q's word (address 0x40+q) empties the queue, and the word reads back unchanged.
- R2: Words written to access address q (0x00+q) are read back from that address in the order they were written. Each read returns its word on the clock edge after the read strobe.
- R3: A write to a full queue stores nothing and sets that queue's overflow flag. The full bit reads 1 exactly when the count equals the queue size.
- R4: A read of an empty queue returns zero and leaves the queue's count and contents unchanged.
- R5: Queues 0 to 31 each report a 4-bit nibble. Queue q uses status word q/8 (address 0x80+q/8), bits 4*(q%8)+3 down to 4*(q%8). Within the nibble, bit 0 is empty, bit 1 is nearly-empty, bit 2 is nearly-full and bit 3 is full.
- R6: Nearly-empty is 1 when the count is at or below the 3-bit threshold in configuration bits 28:26.
- R7: Nearly-full is 1 when the free space (size minus count) is at or below the 3-bit threshold in configuration bits 31:29.
- R8: Queues 32 to 63 report a nearly-empty bit in word 0x86 and a full bit in word 0x87. Queue q uses bit q-32 in both.
- R9: The overflow flags of queues 0 to 31 sit in words 0x84 (queues 0-15) and 0x85 (queues 16-31). Queue q uses bit 2*(q%16)+1, and bit 2*(q%16) always reads 0. Writing 1 to a flag bit clears the flag, and writing 0 to it has no effect.
- R10: After reset, status words 0x80-0x83 read 0x33333333, 0x86 reads 0xFFFFFFFF, and 0x84, 0x85, 0x87 and every configuration word read 0.
- R11: A queue whose configuration word is zero is disabled. Writes to it are dropped without setting overflow, reads of it return 0, and its nibble reads 0x3.
- R12: Each queue wraps inside its own size. Queues placed in different pages do not disturb one another, even when pushes and pops to them are interleaved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 8 | Word address: region in 7:6, queue or status index in 5:0 |
| bus_wr_i | input | 1 | Write strobe, one word per cycle |
| bus_rd_i | input | 1 | Read strobe; dropped when bus_wr_i is also high |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid from the edge after the read strobe |

## Verification
The bench first fills a queue to its exact size and then writes once more. A design that stored the extra word would return a surplus item when the queue is drained, and one that skipped the overflow flag would show a wrong 0x84 word. The bench also pops the drained queue again: a design that moved its pointer there would return stale data, or would return a later word out of order. Interleaved traffic to queues of 16 and 32 words crosses the wrap point several times, so a pointer masked with the wrong size would scramble the scoreboard order. The bench also checks the bit position of every flag in queues 0, 1, 9, 17 and 40, writes a zero clear to an overflow word, disables a queue and reconfigures a queue that still holds data, so a misplaced field or a stale count shows up as a wrong word.

// File: rtl/qm_pkg.sv
package qm_pkg;
   // configuration word fields
   localparam int CFG_BASE_LSB = 14;
   localparam int CFG_SIZE_LSB = 24;
   localparam int CFG_NE_LSB   = 26;
   localparam int CFG_NF_LSB   = 29;
   // per-queue occupancy and pointer widths (max queue is 128 words)
   localparam int QCW = 8;
   localparam int QPW = 7;

   typedef struct packed {
      logic full;
      logic nfull;
      logic nempty;
      logic empty;
   } qstat_t;

   typedef enum logic [1:0] {
      RG_ACCESS = 2'd0,
      RG_CONFIG = 2'd1,
      RG_STATUS = 2'd2,
      RG_NONE   = 2'd3
   } region_e;

   function automatic logic [QCW-1:0] size_words(input logic [1:0] code);
      return QCW'(16) << code;
   endfunction
endpackage

// File: rtl/qm_sram.sv
module qm_sram #(
   parameter int DW    = 32,
   parameter int DEPTH = 1024,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/qm_queue_ctl.sv
module qm_queue_ctl import qm_pkg::*; #(
   parameter int DW  = 32,
   parameter int PGW = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic [DW-1:0]  cfg_wdata,
   input  logic           push,
   input  logic           pop,
   input  logic           ovf_clr,
   output logic [DW-1:0]  cfg_o,
   output logic [PGW-1:0] page_o,
   output logic [QPW-1:0] rd_off_o,
   output logic [QPW-1:0] wr_off_o,
   output qstat_t         stat_o,
   output logic           ovf_o
);
   logic [DW-1:0]  cfg_q;
   logic [QCW-1:0] cnt_q;
   logic [QPW-1:0] rd_q;
   logic           ovf_q;

   logic           en;
   logic [QCW-1:0] size;
   logic [QPW-1:0] mask;
   logic           is_full, is_empty, push_ok, pop_ok;

   assign en       = |cfg_q;
   assign size     = size_words(cfg_q[CFG_SIZE_LSB +: 2]);
   assign mask     = QPW'(size - 1'b1);
   assign is_full  = (cnt_q == size);
   assign is_empty = (cnt_q == '0);
   assign push_ok  = push && en && !is_full;
   assign pop_ok   = pop && en && !is_empty;

   assign cfg_o    = cfg_q;
   assign page_o   = cfg_q[CFG_BASE_LSB +: PGW];
   assign rd_off_o = rd_q;
   assign wr_off_o = (rd_q + cnt_q[QPW-1:0]) & mask;
   assign ovf_o    = ovf_q;

   always_comb begin
      if (!en) begin
         stat_o = '{full: 1'b0, nfull: 1'b0, nempty: 1'b1, empty: 1'b1};
      end else begin
         stat_o.empty  = is_empty;
         stat_o.full   = is_full;
         stat_o.nempty = cnt_q <= QCW'(cfg_q[CFG_NE_LSB +: 3]);
         stat_o.nfull  = (size - cnt_q) <= QCW'(cfg_q[CFG_NF_LSB +: 3]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         cnt_q <= '0;
         rd_q  <= '0;
         ovf_q <= 1'b0;
      end else if (cfg_we) begin
         cfg_q <= cfg_wdata;
         cnt_q <= '0;
         rd_q  <= '0;
         ovf_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q + QCW'(push_ok) - QCW'(pop_ok);
         if (pop_ok) rd_q <= (rd_q + 1'b1) & mask;
         if (push && en && is_full) ovf_q <= 1'b1;
         else if (ovf_clr)          ovf_q <= 1'b0;
      end
   end

   // R3: occupancy never exceeds the configured size
   p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= size);
   // R3: a write into a full, enabled queue raises overflow
   p_full_push_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && en && is_full && !cfg_we) |=> ovf_q);
   // R4: popping an empty queue leaves the count alone
   p_empty_pop_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && is_empty && !push && !cfg_we) |=> $stable(cnt_q));
   // R1: a configuration write leaves the queue empty
   p_cfg_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (cnt_q == '0 && !ovf_q));
   // R11: a disabled queue never holds data
   p_idle_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (cnt_q == '0));
endmodule

// File: rtl/qm_stat_pack.sv
module qm_stat_pack import qm_pkg::*; #(
   parameter int LOWQ  = 32,
   parameter int DW    = 32,
   localparam int NIBW = LOWQ / 8,
   localparam int OVFW = LOWQ / 16
) (
   input  qstat_t        lo_stat_i [LOWQ],
   input  logic          lo_ovf_i  [LOWQ],
   output logic [DW-1:0] nib_o     [NIBW],
   output logic [DW-1:0] ovf_o     [OVFW]
);
   for (genvar w = 0; w < NIBW; w++) begin : g_nw
      for (genvar k = 0; k < 8; k++) begin : g_nk
         assign nib_o[w][4*k +: 4] = lo_stat_i[w*8 + k];
      end
   end

   for (genvar w = 0; w < OVFW; w++) begin : g_ow
      for (genvar k = 0; k < 16; k++) begin : g_ok
         assign ovf_o[w][2*k]   = 1'b0;
         assign ovf_o[w][2*k+1] = lo_ovf_i[w*16 + k];
      end
   end
endmodule

// File: rtl/qm_fifo_mgr.sv
module qm_fifo_mgr import qm_pkg::*; #(
   parameter int NQ         = 64,
   parameter int DW         = 32,
   parameter int PAGES      = 64,
   parameter int PAGE_WORDS = 16,
   localparam int QW        = $clog2(NQ),
   localparam int BUS_AW    = QW + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BUS_AW-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [DW-1:0]     bus_wdata_i,
   output logic [DW-1:0]     bus_rdata_o
);
   localparam int LOWQ      = NQ / 2;
   localparam int DEPTH     = PAGES * PAGE_WORDS;
   localparam int MAW       = $clog2(DEPTH);
   localparam int PGW       = $clog2(PAGES);
   localparam int PWSH      = $clog2(PAGE_WORDS);
   localparam int NIBW      = LOWQ / 8;
   localparam int OVFW      = LOWQ / 16;
   localparam int ST_NIB0   = 0;
   localparam int ST_OVF0   = NIBW;
   localparam int ST_NEHI   = NIBW + OVFW;
   localparam int ST_FULLHI = NIBW + OVFW + 1;

   if (NQ != 2 * DW) begin : g_bad_nq
      $error("NQ must be twice the data width");
   end
   if (DW != 32) begin : g_bad_dw
      $error("data width must be 32");
   end
   if (PAGE_WORDS != 16) begin : g_bad_pw
      $error("pages are 16 words");
   end
   if ((PAGES & (PAGES - 1)) != 0 || PAGES < 8 || PAGES > 256) begin : g_bad_pg
      $error("PAGES must be a power of two in 8..256");
   end

   region_e        rg;
   logic [QW-1:0]  q_sel;
   logic [5:0]     st_idx;
   logic           rd_any, rd_acc, push_any;

   assign rg       = region_e'(bus_addr_i[BUS_AW-1 -: 2]);
   assign q_sel    = bus_addr_i[QW-1:0];
   assign st_idx   = bus_addr_i[5:0];
   assign rd_any   = bus_rd_i && !bus_wr_i;
   assign rd_acc   = rd_any && (rg == RG_ACCESS);
   assign push_any = bus_wr_i && (rg == RG_ACCESS);

   logic [DW-1:0]  cfg_a    [NQ];
   logic [PGW-1:0] page_a   [NQ];
   logic [QPW-1:0] rd_off_a [NQ];
   logic [QPW-1:0] wr_off_a [NQ];
   qstat_t         stat_a   [NQ];
   logic           ovf_a    [NQ];
   qstat_t         lo_stat  [LOWQ];
   logic           lo_ovf   [LOWQ];
   logic [LOWQ-1:0] ne_hi, full_hi;

   for (genvar i = 0; i < NQ; i++) begin : g_q
      logic hit, clr;
      assign hit = (q_sel == QW'(i));
      if (i < LOWQ) begin : g_lo
         assign clr = bus_wr_i && (rg == RG_STATUS) &&
                      (st_idx == 6'(ST_OVF0 + i / 16)) &&
                      bus_wdata_i[2*(i%16)+1];
         assign lo_stat[i] = stat_a[i];
         assign lo_ovf[i]  = ovf_a[i];
      end else begin : g_hi
         assign clr = 1'b0;
         assign ne_hi[i-LOWQ]   = stat_a[i].nempty;
         assign full_hi[i-LOWQ] = stat_a[i].full;
      end
      qm_queue_ctl #(.DW(DW), .PGW(PGW)) u_ctl (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_we    (bus_wr_i && (rg == RG_CONFIG) && hit),
         .cfg_wdata (bus_wdata_i),
         .push      (push_any && hit),
         .pop       (rd_acc && hit),
         .ovf_clr   (clr),
         .cfg_o     (cfg_a[i]),
         .page_o    (page_a[i]),
         .rd_off_o  (rd_off_a[i]),
         .wr_off_o  (wr_off_a[i]),
         .stat_o    (stat_a[i]),
         .ovf_o     (ovf_a[i])
      );
   end

   logic [DW-1:0] nib_w [NIBW];
   logic [DW-1:0] ovf_w [OVFW];

   qm_stat_pack #(.LOWQ(LOWQ), .DW(DW)) u_pack (
      .lo_stat_i (lo_stat),
      .lo_ovf_i  (lo_ovf),
      .nib_o     (nib_w),
      .ovf_o     (ovf_w)
   );

   // shared storage access for the selected queue
   logic           en_sel, full_sel, empty_sel, mem_we, mem_re;
   logic [MAW-1:0] base_sel, mem_waddr, mem_raddr;
   logic [DW-1:0]  mem_rdata;

   assign en_sel    = |cfg_a[q_sel];
   assign full_sel  = stat_a[q_sel].full;
   assign empty_sel = stat_a[q_sel].empty;
   assign base_sel  = MAW'(page_a[q_sel]) << PWSH;
   assign mem_waddr = base_sel + MAW'(wr_off_a[q_sel]);
   assign mem_raddr = base_sel + MAW'(rd_off_a[q_sel]);
   assign mem_we    = push_any && en_sel && !full_sel;
   assign mem_re    = rd_acc && en_sel && !empty_sel;

   qm_sram #(.DW(DW), .DEPTH(DEPTH)) u_sram (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (bus_wdata_i),
      .re    (mem_re),
      .raddr (mem_raddr),
      .rdata (mem_rdata)
   );

   // register read path
   logic [DW-1:0] reg_val, reg_q;
   logic          pop_hit_q;

   always_comb begin
      reg_val = '0;
      case (rg)
         RG_CONFIG: reg_val = cfg_a[q_sel];
         RG_STATUS: begin
            for (int k = 0; k < NIBW; k++)
               if (st_idx == 6'(ST_NIB0 + k)) reg_val = nib_w[k];
            for (int k = 0; k < OVFW; k++)
               if (st_idx == 6'(ST_OVF0 + k)) reg_val = ovf_w[k];
            if (st_idx == 6'(ST_NEHI))   reg_val = DW'(ne_hi);
            if (st_idx == 6'(ST_FULLHI)) reg_val = DW'(full_hi);
         end
         default: reg_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q     <= '0;
         pop_hit_q <= 1'b0;
      end else if (rd_any) begin
         reg_q     <= reg_val;
         pop_hit_q <= mem_re;
      end
   end

   assign bus_rdata_o = pop_hit_q ? mem_rdata : reg_q;

   // R4: reading an empty or disabled queue yields zero next cycle
   p_empty_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && empty_sel) |=> (bus_rdata_o == '0));
   // R11: a write to a disabled queue never reaches storage
   p_disabled_no_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (push_any && !en_sel) |-> !mem_we);
endmodule

// File: tb/sim_qm_fifo_mgr.sv
module sim_qm_fifo_mgr;
   timeunit 1ns; timeprecision 1ps;

   logic        clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n;
   logic [7:0]  addr;
   logic        wr, rd;
   logic [31:0] wdata;
   logic [31:0] rdata;

   qm_fifo_mgr u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr_i  (addr),
      .bus_wr_i    (wr),
      .bus_rd_i    (rd),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model
   logic [31:0] mcfg [64];
   logic [31:0] mq   [64][$];
   bit          movf [64];

   // scoreboard of expected read results
   logic [31:0] expq [$];
   string       tagq [$];
   logic        rd_pend;

   always @(posedge clk) rd_pend <= rst_n && rd && !wr;

   always @(negedge clk) begin : mon
      logic [31:0] e;
      string t;
      if (rd_pend === 1'b1) begin
         checks++;
         if (expq.size() == 0) begin
            errors++;
            $display("FAIL R2 unexpected read got %h exp none", rdata);
         end else begin
            e = expq.pop_front();
            t = tagq.pop_front();
            if (rdata !== e) begin
               errors++;
               $display("FAIL %s got %h exp %h", t, rdata, e);
            end
         end
      end
   end

   function automatic int qsize(int q);
      return 16 << mcfg[q][25:24];
   endfunction

   function automatic logic [3:0] mnib(int q);
      int c;
      if (mcfg[q] == 0) return 4'h3;
      c = mq[q].size();
      return {c == qsize(q), (qsize(q) - c) <= int'(mcfg[q][31:29]),
              c <= int'(mcfg[q][28:26]), c == 0};
   endfunction

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1; rd = 1'b0;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      addr = a; rd = 1'b1; wr = 1'b0;
      expq.push_back(e);
      tagq.push_back(tag);
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic wr_cfg(input int q, input logic [31:0] c);
      bus_write(8'(8'h40 + q), c);
      mcfg[q] = c;
      mq[q].delete();
      movf[q] = 0;
   endtask

   task automatic push(input int q, input logic [31:0] v);
      bus_write(8'(q), v);
      if (mcfg[q] != 0) begin
         if (mq[q].size() < qsize(q)) mq[q].push_back(v);
         else movf[q] = 1;
      end
   endtask

   task automatic pop(input int q, input string tag);
      logic [31:0] e;
      e = 32'h0;
      if (mcfg[q] != 0 && mq[q].size() > 0) e = mq[q].pop_front();
      bus_read(8'(q), e, tag);
   endtask

   task automatic chk_stat(input int w, input string tag);
      logic [31:0] e;
      for (int k = 0; k < 8; k++) e[4*k +: 4] = mnib(w*8 + k);
      bus_read(8'(8'h80 + w), e, tag);
   endtask

   task automatic chk_ovf(input int w, input string tag);
      logic [31:0] e;
      e = 32'h0;
      for (int k = 0; k < 16; k++) e[2*k+1] = movf[w*16 + k];
      bus_read(8'(8'h84 + w), e, tag);
   endtask

   task automatic chk_hi(input string tag);
      logic [31:0] ne, fu;
      for (int k = 0; k < 32; k++) begin
         ne[k] = mnib(32 + k)[1];
         fu[k] = mnib(32 + k)[3];
      end
      bus_read(8'h86, ne, tag);
      bus_read(8'h87, fu, tag);
   endtask

   function automatic logic [31:0] mk_cfg(int page, int code, int ne, int nf);
      return (32'(nf) << 29) | (32'(ne) << 26) | (32'(code) << 24) | (32'(page) << 14);
   endfunction

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R2 watchdog got timeout exp completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] c0, c1;
      rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
      for (int q = 0; q < 64; q++) begin mcfg[q] = 0; movf[q] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R10: reset state
      for (int w = 0; w < 4; w++) chk_stat(w, "R10 nibble reset");
      chk_ovf(0, "R10 ovf reset");
      chk_ovf(1, "R10 ovf reset");
      chk_hi("R10 upper reset");
      bus_read(8'h45, 32'h0, "R10 cfg reset");

      // R11: disabled queue
      push(3, 32'hdeadbeef);
      pop(3, "R11 disabled read");
      chk_stat(0, "R11 disabled nibble");
      chk_ovf(0, "R11 no overflow");

      // R1: config readback
      c0 = mk_cfg(4, 0, 2, 3);
      wr_cfg(0, c0);
      bus_read(8'h40, c0, "R1 cfg readback");

      // R2, R6: ordering and nearly-empty threshold
      for (int k = 0; k < 5; k++) begin
         push(0, 32'h1000 + k);
         chk_stat(0, "R6 nearly-empty");
      end
      for (int k = 0; k < 5; k++) pop(0, "R2 order");

      // R3, R5, R7: fill, nearly-full, full, dropped write
      for (int k = 0; k < 16; k++) begin
         push(0, 32'h2000 + k);
         if (k >= 11) chk_stat(0, "R7 nearly-full");
      end
      chk_stat(0, "R5 full nibble");
      push(0, 32'h0bad0bad);
      chk_ovf(0, "R3 overflow flag");
      for (int k = 0; k < 16; k++) pop(0, "R3 dropped write");
      pop(0, "R4 empty read");
      chk_stat(0, "R4 still empty");
      pop(0, "R4 second empty read");

      // R9: write-1-to-clear
      bus_write(8'h84, 32'h0);
      chk_ovf(0, "R9 zero write keeps flag");
      bus_write(8'h84, 32'h2);
      movf[0] = 0;
      chk_ovf(0, "R9 flag cleared");

      // R12: wrap within a 16-word queue
      for (int r = 0; r < 3; r++) begin
         for (int k = 0; k < 11; k++) push(0, 32'h3000 + r*16 + k);
         for (int k = 0; k < 11; k++) pop(0, "R12 wrap q0");
      end

      // R1, R12: a 32-word queue beside q0
      c1 = mk_cfg(5, 1, 0, 0);
      wr_cfg(1, c1);
      for (int k = 0; k < 32; k++) begin
         push(1, 32'h4100 + k);
         if (k < 6) push(0, 32'h4000 + k);
         if (k == 15) chk_stat(0, "R1 size32 not full at 16");
      end
      chk_stat(0, "R1 size32 full at 32");
      push(1, 32'h0eeeeeee);
      chk_ovf(0, "R9 q1 overflow position");
      for (int k = 0; k < 32; k++) begin
         pop(1, "R12 q1 interleave");
         if (k < 6) pop(0, "R12 q0 interleave");
      end

      // R5: nibble position for queue 9
      wr_cfg(9, mk_cfg(10, 1, 7, 7));
      push(9, 32'h9999);
      chk_stat(1, "R5 q9 nibble");

      // R9: queue 17 overflow in second word
      wr_cfg(17, mk_cfg(12, 0, 0, 0));
      for (int k = 0; k < 17; k++) push(17, 32'h1700 + k);
      chk_ovf(1, "R9 q17 overflow");
      bus_write(8'h85, 32'h8);
      movf[17] = 0;
      chk_ovf(1, "R9 q17 cleared");

      // R8: upper queue flags
      wr_cfg(40, mk_cfg(16, 1, 1, 0));
      chk_hi("R8 upper empty");
      for (int k = 0; k < 2; k++) push(40, 32'h4000_0000 + k);
      chk_hi("R8 upper above threshold");
      for (int k = 2; k < 33; k++) push(40, 32'h4000_0000 + k);
      chk_hi("R8 upper full");
      for (int k = 0; k < 32; k++) pop(40, "R8 upper data");
      chk_hi("R8 upper drained");

      // R11: disabling a queue with data
      wr_cfg(9, 32'h0);
      pop(9, "R11 disabled after data");
      chk_stat(1, "R11 disabled nibble");

      // R1: reconfigure clears content
      for (int k = 0; k < 3; k++) push(0, 32'h5000 + k);
      wr_cfg(0, c0);
      pop(0, "R1 reconfig empties");
      chk_stat(0, "R1 reconfig status");

      repeat (4) @(negedge clk);
      if (expq.size() != 0) begin
         errors++;
         $display("FAIL R2 pending reads got %0d exp 0", expq.size());
      end
      done = 1;
      summary();
      $finish;
   end
endmodule